// File: doc/BRIEF.md
# Serial Stereo Audio Output Formatter

This block turns parallel left/right sample pairs into a three-wire serial audio stream: a bit clock, a channel-select clock and one serial data line. It runs entirely in the system clock domain; a clock-enable tick paces an integer divider that sets the bit-clock half-period. Each sample frame holds 32, 48 or 64 bit-clock periods. Every frame is split into a left half and a right half, and each half carries one 16-bit sample followed by zero padding.

Samples enter through a valid/ready handshake into a one-pair holding register. At each frame boundary, which is the start of the left half, the held pair moves into the active frame. The frame mode, the channel-clock polarity, the bit order and the divider value are sampled at that same boundary. If no pair is held when a boundary arrives, the frame is filled with zeros and an underflow flag pulses. The serial data and the channel clock change only as the bit clock falls, so a receiver can capture on the rising edge.

Top module: `aud_ser_fmt`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `bclk`, `lrclk`, `sdata` and `underflow` are 0 and `s_ready` is 1.
- R2: `bclk` toggles only in cycles where `tick` is high. Each half-period lasts max(`cfg_half_div`,1) ticks.
- R3: The `cfg_frame_mode` code sets the frame length in bit-clock periods: code 0 gives 32, code 1 gives 48, and codes 2 and 3 give 64.
- R4: With `cfg_lr_inv`=0, `lrclk` is low for the left half-frame (the first half) and high for the right half-frame. With `cfg_lr_inv`=1 both levels are inverted.
- R5: With `cfg_lsb_first`=0, slot p of a half-frame (p counted from 0) carries bit 15-p of that channel's sample.
- R6: With `cfg_lsb_first`=1, slot p of a half-frame carries bit p of that channel's sample.
- R7: In every half-frame, slots 16 and above carry 0.
- R8: `lrclk` and `sdata` change only on the clock edge where `bclk` goes from 1 to 0.
- R9: `cfg_frame_mode`, `cfg_lr_inv`, `cfg_lsb_first` and `cfg_half_div` are sampled only at a frame boundary. A change made mid-frame leaves the current frame unchanged.
- R10: If no pair is held at a frame boundary, the whole frame carries zeros. In that case `underflow` is high for exactly one cycle, on the same edge as the `bclk` fall that starts the frame.
- R11: `s_ready` is high exactly when the holding register is empty. A pair is accepted when `s_valid` and `s_ready` are both high, and `s_ready` then stays low until the next boundary. The accepted pair is sent in the frame that starts at that boundary, with no underflow for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Clock enable that paces the bit-clock divider |
| cfg_frame_mode | input | 2 | Frame length code (0:32, 1:48, 2/3:64) |
| cfg_lr_inv | input | 1 | Inverts the channel clock levels |
| cfg_lsb_first | input | 1 | 1 sends the LSB first, 0 sends the MSB first |
| cfg_half_div | input | DIV_W | Bit-clock half-period in ticks (0 is treated as 1) |
| s_valid | input | 1 | A sample pair is offered |
| s_ready | output | 1 | The holding register is empty |
| s_left | input | SAMPLE_W | Left-channel sample |
| s_right | input | SAMPLE_W | Right-channel sample |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Channel clock |
| sdata | output | 1 | Serial data |
| underflow | output | 1 | One-cycle pulse when a frame starts without a pair |

## Verification
The hardest cases to reach from the ports are those whose effect depends on where they fall inside a frame. Examples are a configuration write part-way through a frame, or a pair offered at a known point relative to the next boundary. The bench rebuilds frames from the pins themselves. It finds each frame start at the first rising bit-clock edge that shows the left-channel level after a right-channel one, and it places stimulus a fixed number of cycles after that point. A mid-frame mode and order change must therefore leave one whole old-format frame in place before a new-format frame appears. A single pair offered just after a frame start must appear in exactly the next frame, with zero-filled frames around it.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

  localparam int SLOT_W = 6;

  typedef enum logic [1:0] {
    FM_32  = 2'd0,
    FM_48  = 2'd1,
    FM_64  = 2'd2,
    FM_64B = 2'd3
  } frame_mode_e;

  typedef struct packed {
    logic [1:0] mode;
    logic       lr_inv;
    logic       lsb_first;
  } fmt_cfg_t;

  // bit-clock periods in one frame for a mode code
  function automatic logic [SLOT_W:0] frame_slots(input logic [1:0] m);
    case (m)
      FM_32:   return (SLOT_W+1)'(32);
      FM_48:   return (SLOT_W+1)'(48);
      default: return (SLOT_W+1)'(64);
    endcase
  endfunction

endpackage

// File: rtl/aud_bclk_div.sv
module aud_bclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [DIV_W-1:0] half_div,
  output logic             bclk,
  output logic             fall_evt
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] term;
  logic             wrap;

  always_comb term = (half_div == '0) ? '0 : half_div - 1'b1;

  assign wrap     = tick && (cnt >= term);
  assign fall_evt = wrap && bclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (tick) begin
      if (cnt >= term) begin
        cnt  <= '0;
        bclk <= ~bclk;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/aud_frame_seq.sv
module aud_frame_seq
  import aud_ser_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall_evt,
  input  fmt_cfg_t          cfg_in,
  input  logic [DIV_W-1:0]  half_in,
  output logic              boundary,
  output logic [SLOT_W-1:0] nxt_slot,
  output logic [SLOT_W:0]   nxt_half_slots,
  output logic              nxt_lsb,
  output logic [DIV_W-1:0]  act_half,
  output logic              lrclk
);

  fmt_cfg_t          act;
  fmt_cfg_t          nxt;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W:0]   act_slots;
  logic              last_slot;
  logic              nxt_right;

  always_comb begin
    act_slots      = frame_slots(act.mode);
    last_slot      = ({1'b0, slot_q} == act_slots - 1'b1);
    boundary       = fall_evt && last_slot;
    nxt            = boundary ? cfg_in : act;
    nxt_slot       = boundary ? '0 : slot_q + 1'b1;
    nxt_half_slots = frame_slots(nxt.mode) >> 1;
    nxt_lsb        = nxt.lsb_first;
    nxt_right      = ({1'b0, nxt_slot} >= nxt_half_slots);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q        <= SLOT_W'(31);
      act.mode      <= FM_32;
      act.lr_inv    <= 1'b0;
      act.lsb_first <= 1'b0;
      act_half      <= DIV_W'(1);
      lrclk         <= 1'b0;
    end else if (fall_evt) begin
      slot_q <= nxt_slot;
      lrclk  <= nxt_right ^ nxt.lr_inv;
      if (boundary) begin
        act      <= cfg_in;
        act_half <= half_in;
      end
    end
  end

endmodule

// File: rtl/aud_slot_ser.sv
module aud_slot_ser
  import aud_ser_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  input  logic                boundary,
  input  logic                fall_evt,
  input  logic [SLOT_W-1:0]   nxt_slot,
  input  logic [SLOT_W:0]     nxt_half_slots,
  input  logic                nxt_lsb,
  output logic                sdata,
  output logic                underflow
);

  localparam int NCH = 2;

  logic                           hold_full;
  logic                           acc;
  logic [NCH-1:0][SAMPLE_W-1:0]   in_w;
  logic [NCH-1:0][SAMPLE_W-1:0]   hold_w;
  logic [NCH-1:0][SAMPLE_W-1:0]   cur_w;
  logic [NCH-1:0][SAMPLE_W-1:0]   load_w;

  assign in_w    = {s_right, s_left};
  assign s_ready = ~hold_full;
  assign acc     = s_valid && ~hold_full;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SAMPLE_W-1:0] hold_r;
    logic [SAMPLE_W-1:0] cur_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        hold_r <= '0;
        cur_r  <= '0;
      end else begin
        if (acc)      hold_r <= in_w[c];
        if (boundary) cur_r  <= load_w[c];
      end
    end

    assign hold_w[c] = hold_r;
    assign cur_w[c]  = cur_r;
    assign load_w[c] = hold_full ? hold_r : '0;
  end

  logic                chan_right;
  logic [SLOT_W:0]     pos;
  logic [SLOT_W:0]     idx;
  logic [SAMPLE_W-1:0] word;
  logic                bit_nx;

  always_comb begin
    chan_right = ({1'b0, nxt_slot} >= nxt_half_slots);
    pos        = chan_right ? {1'b0, nxt_slot} - nxt_half_slots : {1'b0, nxt_slot};
    word       = boundary ? load_w[chan_right] : cur_w[chan_right];
    idx        = nxt_lsb ? pos : (SLOT_W+1)'(SAMPLE_W-1) - pos;
    bit_nx     = 1'b0;
    if (pos < (SLOT_W+1)'(SAMPLE_W)) begin
      for (int b = 0; b < SAMPLE_W; b++) begin
        if (idx == (SLOT_W+1)'(b)) bit_nx = word[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      sdata     <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (acc)           hold_full <= 1'b1;
      else if (boundary) hold_full <= 1'b0;
      underflow <= boundary && ~hold_full;
      if (fall_evt) sdata <= bit_nx;
    end
  end

endmodule

// File: rtl/aud_ser_fmt.sv
module aud_ser_fmt
  import aud_ser_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int DIV_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic [1:0]          cfg_frame_mode,
  input  logic                cfg_lr_inv,
  input  logic                cfg_lsb_first,
  input  logic [DIV_W-1:0]    cfg_half_div,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  output logic                bclk,
  output logic                lrclk,
  output logic                sdata,
  output logic                underflow
);

  fmt_cfg_t          cfg_in;
  logic              fall_evt;
  logic              boundary;
  logic [SLOT_W-1:0] nxt_slot;
  logic [SLOT_W:0]   nxt_half_slots;
  logic              nxt_lsb;
  logic [DIV_W-1:0]  act_half;

  always_comb begin
    cfg_in.mode      = cfg_frame_mode;
    cfg_in.lr_inv    = cfg_lr_inv;
    cfg_in.lsb_first = cfg_lsb_first;
  end

  aud_bclk_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .half_div (act_half),
    .bclk     (bclk),
    .fall_evt (fall_evt)
  );

  aud_frame_seq #(.DIV_W(DIV_W)) u_seq (
    .clk            (clk),
    .rst            (rst),
    .fall_evt       (fall_evt),
    .cfg_in         (cfg_in),
    .half_in        (cfg_half_div),
    .boundary       (boundary),
    .nxt_slot       (nxt_slot),
    .nxt_half_slots (nxt_half_slots),
    .nxt_lsb        (nxt_lsb),
    .act_half       (act_half),
    .lrclk          (lrclk)
  );

  aud_slot_ser #(.SAMPLE_W(SAMPLE_W)) u_ser (
    .clk            (clk),
    .rst            (rst),
    .s_valid        (s_valid),
    .s_ready        (s_ready),
    .s_left         (s_left),
    .s_right        (s_right),
    .boundary       (boundary),
    .fall_evt       (fall_evt),
    .nxt_slot       (nxt_slot),
    .nxt_half_slots (nxt_half_slots),
    .nxt_lsb        (nxt_lsb),
    .sdata          (sdata),
    .underflow      (underflow)
  );

endmodule

// File: rtl/aud_ser_chk.sv
module aud_ser_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic s_valid,
  input logic s_ready,
  input logic bclk,
  input logic lrclk,
  input logic sdata,
  input logic underflow
);

  // R1: outputs at their reset values on the first cycle after reset
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bclk && !lrclk && !sdata && !underflow && s_ready));

  // R2: the bit clock moves only on tick cycles
  a_r2_bclk_on_tick: assert property (@(posedge clk) disable iff (rst)
    (bclk != $past(bclk)) |-> $past(tick));

  // R8: channel clock changes only with a falling bit clock
  a_r8_lr_on_fall: assert property (@(posedge clk) disable iff (rst)
    (lrclk != $past(lrclk)) |-> ($past(bclk) && !bclk));

  // R8: serial data changes only with a falling bit clock
  a_r8_sd_on_fall: assert property (@(posedge clk) disable iff (rst)
    (sdata != $past(sdata)) |-> ($past(bclk) && !bclk));

  // R10: underflow is a single-cycle pulse
  a_r10_uf_single: assert property (@(posedge clk) disable iff (rst)
    underflow |=> !underflow);

  // R10: underflow coincides with the falling bit clock that opens a frame
  a_r10_uf_at_fall: assert property (@(posedge clk) disable iff (rst)
    underflow |-> ($past(bclk) && !bclk));

  // R11: an accepted pair closes the handshake
  a_r11_ready_drop: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> !s_ready);

endmodule

bind aud_ser_fmt aud_ser_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .bclk      (bclk),
  .lrclk     (lrclk),
  .sdata     (sdata),
  .underflow (underflow)
);

// File: tb/test_aud_ser_fmt.sv
module test_aud_ser_fmt;

  localparam int SW    = 16;
  localparam int DIV_W = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b1;
  logic          tick_alt = 1'b0;
  logic [1:0]    cfg_mode = 2'd0;
  logic          cfg_inv = 1'b0;
  logic          cfg_lsb = 1'b0;
  logic [DIV_W-1:0] cfg_half = 8'd1;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [SW-1:0] s_left = '0;
  logic [SW-1:0] s_right = '0;
  logic          bclk, lrclk, sdata, underflow;

  int nchk = 0;
  int nfail = 0;

  aud_ser_fmt #(.SAMPLE_W(SW), .DIV_W(DIV_W)) i_aud_ser_fmt (
    .clk(clk), .rst(rst), .tick(tick),
    .cfg_frame_mode(cfg_mode), .cfg_lr_inv(cfg_inv), .cfg_lsb_first(cfg_lsb),
    .cfg_half_div(cfg_half),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .bclk(bclk), .lrclk(lrclk), .sdata(sdata), .underflow(underflow)
  );

  always #2 clk = ~clk;

  always @(negedge clk) tick <= tick_alt ? ~tick : 1'b1;

  // pin-level frame receiver
  logic        mon_inv = 1'b0;
  logic        pb = 1'b0, plr = 1'b0, psd = 1'b0, puf = 1'b0;
  logic        last_rise_lr = 1'b1;
  int          cyc = 0, last_rise = 0, period = 0;
  int          frame_cnt = 0, fr_bits = 0, cur_bits = 0;
  logic [63:0] fr_dat = '0, fr_lr = '0, cur_dat = '0, cur_lr = '0;
  int          r8_viol = 0, uf_cyc = 0, uf_rise = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      last_rise_lr = ~mon_inv;
      cur_bits = 0; cur_dat = '0; cur_lr = '0;
      frame_cnt = 0; uf_cyc = 0; uf_rise = 0;
    end else begin
      if ((lrclk !== plr || sdata !== psd) && !(pb && !bclk)) r8_viol++;
      if (underflow) uf_cyc++;
      if (underflow && !puf) uf_rise++;
      if (bclk && !pb) begin
        period = cyc - last_rise;
        last_rise = cyc;
        if (lrclk == mon_inv && last_rise_lr != mon_inv) begin
          fr_bits = cur_bits; fr_dat = cur_dat; fr_lr = cur_lr;
          frame_cnt++;
          cur_bits = 0; cur_dat = '0; cur_lr = '0;
        end
        if (cur_bits < 64) begin
          cur_dat[cur_bits] = sdata;
          cur_lr[cur_bits]  = lrclk;
        end
        cur_bits++;
        last_rise_lr = lrclk;
      end
    end
    pb = bclk; plr = lrclk; psd = sdata; puf = underflow;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int fbits(input int m);
    return (m == 0) ? 32 : (m == 1) ? 48 : 64;
  endfunction

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_frames(input int n);
    int base;
    base = frame_cnt;
    while (frame_cnt < base + n) @(negedge clk);
  endtask

  task automatic chk_frame(input int m, input bit inv, input bit lsb,
                           input logic [15:0] l, input logic [15:0] r, input string req);
    logic [63:0] ed, el;
    int n, h, p;
    n = fbits(m); h = n / 2;
    ed = '0; el = '0;
    for (int s = 0; s < n; s++) begin
      p = (s >= h) ? s - h : s;
      el[s] = (s >= h) ^ inv;
      if (p < 16) ed[s] = (s >= h) ? (lsb ? r[p] : r[15-p]) : (lsb ? l[p] : l[15-p]);
    end
    chk(fr_bits == n, req, "frame length", fr_bits, n);
    chk(fr_dat == ed, req, "frame data", fr_dat, ed);
    chk(fr_lr == el, req, "channel clock pattern", fr_lr, el);
  endtask

  task automatic t_reset();
    s_valid = 1'b0;
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(bclk == 1'b0, "R1", "bclk in reset", bclk, 0);
    chk(lrclk == 1'b0, "R1", "lrclk in reset", lrclk, 0);
    chk(sdata == 1'b0, "R1", "sdata in reset", sdata, 0);
    chk(underflow == 1'b0, "R1", "underflow in reset", underflow, 0);
    chk(s_ready == 1'b1, "R1", "s_ready in reset", s_ready, 1);
    rst = 1'b0;
  endtask

  task automatic t_fmt(input int m, input bit inv, input bit lsb, input int half,
                       input logic [15:0] l, input logic [15:0] r, input string req);
    cfg_mode = 2'(m); cfg_inv = inv; cfg_lsb = lsb; cfg_half = 8'(half);
    mon_inv = inv; tick_alt = 1'b0;
    s_left = l; s_right = r; s_valid = 1'b1;
    do_reset();
    wait_frames(3);
    chk_frame(m, inv, lsb, l, r, req);
    chk(uf_rise == 0, "R11", "underflow with steady supply", uf_rise, 0);
  endtask

  task automatic t_rate();
    cfg_mode = 2'd0; cfg_inv = 1'b0; cfg_lsb = 1'b0; cfg_half = 8'd3;
    mon_inv = 1'b0; s_valid = 1'b1; tick_alt = 1'b0;
    do_reset();
    wait_frames(2);
    chk(period == 6, "R2", "bclk period, tick every cycle, half 3", period, 6);
    cfg_half = 8'd2; tick_alt = 1'b1;
    do_reset();
    wait_frames(2);
    chk(period == 8, "R2", "bclk period, tick every other cycle, half 2", period, 8);
    tick_alt = 1'b0;
  endtask

  task automatic t_underflow();
    cfg_mode = 2'd0; cfg_inv = 1'b0; cfg_lsb = 1'b0; cfg_half = 8'd1;
    mon_inv = 1'b0; s_valid = 1'b0; s_left = 16'hFFFF; s_right = 16'hFFFF;
    do_reset();
    wait_frames(3);
    chk(fr_dat == 64'd0, "R10", "starved frame data", fr_dat, 0);
    chk(uf_cyc == uf_rise, "R10", "underflow pulse width", uf_cyc, uf_rise);
    chk(uf_rise == frame_cnt, "R10", "one underflow per frame", uf_rise, frame_cnt);
  endtask

  task automatic t_handshake();
    int u0;
    cfg_mode = 2'd0; cfg_inv = 1'b0; cfg_lsb = 1'b0; cfg_half = 8'd1;
    mon_inv = 1'b0; s_valid = 1'b0;
    do_reset();
    wait_frames(2);
    s_left = 16'hC0DE; s_right = 16'h3A71; s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    chk(s_ready == 1'b0, "R11", "s_ready after accept", s_ready, 0);
    u0 = uf_rise;
    wait_frames(2);
    chk_frame(0, 1'b0, 1'b0, 16'hC0DE, 16'h3A71, "R11");
    chk(uf_rise - u0 == 1, "R11", "underflows around single pair", uf_rise - u0, 1);
    chk(s_ready == 1'b1, "R11", "s_ready after pair moved out", s_ready, 1);
  endtask

  task automatic t_midcfg();
    cfg_mode = 2'd0; cfg_inv = 1'b0; cfg_lsb = 1'b0; cfg_half = 8'd1;
    mon_inv = 1'b0; s_left = 16'h9A3C; s_right = 16'h0F81; s_valid = 1'b1;
    do_reset();
    wait_frames(2);
    repeat (20) @(negedge clk);
    cfg_mode = 2'd2; cfg_lsb = 1'b1;
    wait_frames(1);
    chk_frame(0, 1'b0, 1'b0, 16'h9A3C, 16'h0F81, "R9");
    wait_frames(1);
    chk_frame(2, 1'b0, 1'b1, 16'h9A3C, 16'h0F81, "R9");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_fmt(0, 1'b0, 1'b0, 2, 16'hA5C3, 16'h1234, "R3 R4 R5");
    t_fmt(1, 1'b0, 1'b1, 1, 16'h8001, 16'h7FFE, "R3 R6 R7");
    t_fmt(2, 1'b1, 1'b0, 3, 16'hFFFF, 16'h0F0F, "R3 R4 R7");
    t_fmt(3, 1'b0, 1'b1, 1, 16'h6B2D, 16'hE417, "R3 R6");
    t_rate();
    t_underflow();
    t_handshake();
    t_midcfg();
    chk(r8_viol == 0, "R8", "changes outside falling bclk", r8_viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule